// File: doc/BRIEF.md
# Buffer-Filling DMA Write Engine

This block is the device-side half of a direct-to-memory transfer. A peripheral hands it a stream of bytes. Each byte goes into a memory buffer at the next address, and the processor does not touch the data on the way. Software loads the buffer's first address and its byte count through a small register port, then issues a go command. The engine then takes bytes through a valid/ready handshake and asks for the shared memory bus once for every byte. When the bus is granted, it performs one write. When the last byte of the buffer has landed, it raises a single interrupt.

The memory bus is shared with the processor, so every write waits for an arbiter grant. While a byte waits for that grant, the engine holds the address and data steady and stops accepting input. The stream is slowed down and no data is lost. A status word shows whether the engine is running, whether it has finished, and how many bytes are still to come. Reading that word, or writing the acknowledge bit, clears the finished flag and lowers the interrupt.

Top module: `bufdma_engine`

## Requirements
- R1: The register port decodes `cfg_addr` as follows: 0 is the buffer start address, 1 is the byte count, 2 is control (write only, reads as 0) and 3 is status. Start address and byte count read back the last value written and are 0 after reset.
- R2: While no transfer is running, `in_ready` and `bus_req` stay low, whatever `in_valid` does.
- R3: Writing control with bit 0 set starts a transfer, provided the engine is idle and the byte count is nonzero. Busy is set, done is cleared, and the write address and remaining count are loaded from the programmed registers.
- R4: Accepted bytes are written in arrival order. The k-th accepted byte (counting from 0) goes to start address + k, and each grant completes exactly one write.
- R5: `bus_req` is high only while a byte is pending during a transfer. `mem_addr` and `mem_wdata` hold steady until the cycle in which `bus_gnt` is seen.
- R6: `in_ready` is low while a byte waits for the bus.
- R7: In a granted cycle the write address rises by one and the remaining count falls by one. Both are visible from the next cycle on.
- R8: `irq` rises once, on the edge at which the final byte's write completes, and busy drops on that same edge. `irq` is never high while busy, and it stays high until acknowledged.
- R9: Either of two actions acknowledges completion and lowers `irq` on the next edge: a read of status (`cfg_re` at offset 3), or a control write with bit 1 set.
- R10: A go command issued while busy is ignored. The running transfer keeps its address and remaining count, even if the start and count registers are rewritten.
- R11: A go command with a byte count of 0 sets done and `irq` on the next edge, never sets busy, and makes no bus request.
- R12: If the final write completes in the same cycle as an acknowledge, completion wins and done stays set.
- R13: The status word has busy at bit 0, done at bit 1 and the remaining count at bits [CNT_W+1:2]. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe (acknowledges completion at the status offset) |
| cfg_addr | input | 2 | Register offset |
| cfg_wdata | input | REG_W | Register write data |
| cfg_rdata | output | REG_W | Register read data, combinational from the offset |
| in_valid | input | 1 | Incoming byte valid |
| in_ready | output | 1 | Engine can take a byte |
| in_data | input | DATA_W | Incoming byte |
| bus_req | output | 1 | Memory bus request |
| bus_gnt | input | 1 | Memory bus grant; a write completes in a cycle with request and grant both high |
| mem_addr | output | ADDR_W | Write address |
| mem_wdata | output | DATA_W | Write data |
| irq | output | 1 | Completion interrupt, level, held until acknowledged |

## Verification
Two things can land in the same clock edge: the granted write of the final byte, which sets done, and a software acknowledge, which clears it. The bench sets this up by leaving the last byte pending with the grant held low. It then raises the grant and a status read together in one cycle. The status value read in that cycle must still show busy with one byte left. After the edge, `irq` must be high, and a further status read must report done. A scoreboard compares every granted write with the address and data predicted when the byte was accepted, under grants that are always on, alternating, withheld, or forced for a single cycle.

// File: rtl/bufdma_pkg.sv
package bufdma_pkg;

  typedef enum logic [1:0] {
    OFS_BASE = 2'd0,
    OFS_LEN  = 2'd1,
    OFS_CTRL = 2'd2,
    OFS_STAT = 2'd3
  } bufdma_ofs_e;

  localparam int CTRL_GO_BIT  = 0;
  localparam int CTRL_ACK_BIT = 1;

endpackage

// File: rtl/bufdma_regs.sv
module bufdma_regs
  import bufdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_re,
  input  logic [1:0]        cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              st_busy,
  input  logic              st_done,
  input  logic [CNT_W-1:0]  st_remain,
  output logic [ADDR_W-1:0] base_q,
  output logic [CNT_W-1:0]  len_q,
  output logic              go_o,
  output logic              ack_o
);

  bufdma_ofs_e ofs;
  logic        base_en, len_en;

  assign ofs     = bufdma_ofs_e'(cfg_addr);
  assign base_en = cfg_we && (ofs == OFS_BASE);
  assign len_en  = cfg_we && (ofs == OFS_LEN);
  assign go_o    = cfg_we && (ofs == OFS_CTRL) && cfg_wdata[CTRL_GO_BIT];
  assign ack_o   = (cfg_we && (ofs == OFS_CTRL) && cfg_wdata[CTRL_ACK_BIT])
                || (cfg_re && (ofs == OFS_STAT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
    end else begin
      if (base_en) base_q <= cfg_wdata[ADDR_W-1:0];
      if (len_en)  len_q  <= cfg_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    unique case (ofs)
      OFS_BASE: cfg_rdata[ADDR_W-1:0] = base_q;
      OFS_LEN:  cfg_rdata[CNT_W-1:0]  = len_q;
      OFS_CTRL: cfg_rdata = '0;
      OFS_STAT: begin
        cfg_rdata[0]         = st_busy;
        cfg_rdata[1]         = st_done;
        cfg_rdata[2 +: CNT_W] = st_remain;
      end
      default:  cfg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/bufdma_xfer.sv
module bufdma_xfer #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              ack,
  input  logic              beat,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  len,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  remain
);

  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  rem_q,  rem_d;
  logic              last_beat;

  assign last_beat = beat && (rem_q == CNT_W'(1));

  // Order matters: acknowledge first, so a completion in the same cycle wins.
  always_comb begin
    busy_d = busy_q;
    done_d = done_q;
    addr_d = addr_q;
    rem_d  = rem_q;
    if (ack) done_d = 1'b0;
    if (go && !busy_q) begin
      addr_d = base;
      rem_d  = len;
      busy_d = (len != '0);
      done_d = (len == '0);
    end
    if (beat) begin
      addr_d = addr_q + ADDR_W'(1);
      rem_d  = rem_q - CNT_W'(1);
    end
    if (last_beat) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
      rem_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      addr_q <= addr_d;
      rem_q  <= rem_d;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign cur_addr = addr_q;
  assign remain   = rem_q;

endmodule

// File: rtl/bufdma_stage.sv
module bufdma_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [DATA_W-1:0] wdata,
  output logic              beat
);

  logic              pend_q, pend_d;
  logic [DATA_W-1:0] data_q;
  logic              take;

  assign in_ready = busy && !pend_q;
  assign take     = in_valid && in_ready;
  assign bus_req  = pend_q;
  assign beat     = pend_q && bus_gnt;

  always_comb begin
    pend_d = pend_q;
    if (take) pend_d = 1'b1;
    if (beat) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      data_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (take) data_q <= in_data;
    end
  end

  assign wdata = data_q;

endmodule

// File: rtl/bufdma_engine.sv
module bufdma_engine #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_re,
  input  logic [1:0]        cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              irq
);

  logic              rst_meta, rst_sync_n;
  logic [ADDR_W-1:0] base_w;
  logic [CNT_W-1:0]  len_w, remain_w;
  logic              go_w, ack_w, beat_w, busy_w, done_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  bufdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .st_busy(busy_w), .st_done(done_w), .st_remain(remain_w),
    .base_q(base_w), .len_q(len_w), .go_o(go_w), .ack_o(ack_w)
  );

  bufdma_xfer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_xfer (
    .clk(clk), .rst_n(rst_sync_n),
    .go(go_w), .ack(ack_w), .beat(beat_w),
    .base(base_w), .len(len_w),
    .busy(busy_w), .done(done_w), .cur_addr(mem_addr), .remain(remain_w)
  );

  bufdma_stage #(.DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst_n(rst_sync_n), .busy(busy_w),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .wdata(mem_wdata), .beat(beat_w)
  );

  assign irq = done_w;

endmodule

// File: rtl/bufdma_engine_chk.sv
module bufdma_engine_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              irq,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              in_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [CNT_W-1:0]  remain
);

  AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> busy); // R5
  AST_HOLD_UNTIL_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(mem_addr) && $stable(mem_wdata))); // R5
  AST_NO_READY_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !in_ready); // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt) |=> (mem_addr == $past(mem_addr) + ADDR_W'(1))); // R7
  AST_REMAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt) |=> (remain == $past(remain) - CNT_W'(1))); // R7
  AST_IRQ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy); // R8
  AST_END_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq); // R8

endmodule

bind bufdma_engine bufdma_engine_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .busy(busy_w), .irq(irq),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .in_ready(in_ready),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .remain(remain_w)
);

// File: tb/bufdma_engine_bench.sv
module bufdma_engine_bench;

  logic        clk, rst_n;
  logic        cfg_we, cfg_re;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        in_valid, in_ready;
  logic [7:0]  in_data;
  logic        bus_req, bus_gnt;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        irq;

  int          nchk = 0;
  int          nerr = 0;
  logic [39:0] exp_q[$];
  logic [31:0] exp_addr;
  logic [1:0]  gnt_mode;
  logic        force_gnt, phase;
  logic [31:0] rd;

  bufdma_engine u_bufdma_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_re(cfg_re),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) phase <= ~phase;
  assign bus_gnt = force_gnt | (gnt_mode == 2'd1) | ((gnt_mode == 2'd2) && phase);

  task automatic check(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: every granted write pops the predicted item
  always @(negedge clk) begin
    #2;
    if (rst_n && bus_req && bus_gnt) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected write", {mem_addr, mem_wdata}, 40'h0);
      end else begin
        logic [39:0] e;
        e = exp_q.pop_front();
        check({mem_addr, mem_wdata} == e, "R4 write addr/data", {mem_addr, mem_wdata}, e);
      end
    end
  end

  task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_re = 1'b1; cfg_addr = a;
    #1 d = cfg_rdata;
    @(negedge clk);
    cfg_re = 1'b0;
  endtask

  // Driver: offers one byte and pushes its expected write once accepted
  task automatic send_byte(input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_data = d;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back({exp_addr, d});
    exp_addr = exp_addr + 1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_re = 1'b0; cfg_addr = 2'd0; cfg_wdata = '0;
    in_valid = 1'b0; in_data = '0; gnt_mode = 2'd0; force_gnt = 1'b0; phase = 1'b0;
    exp_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Reset state: R2, R13, R1
    #1;
    check(irq == 1'b0, "R8 irq after reset", 40'(irq), 40'h0);
    check(bus_req == 1'b0 && in_ready == 1'b0, "R2 idle after reset", {bus_req, in_ready}, 40'h0);
    read_reg(2'd3, rd);
    check(rd == 32'h0, "R13 status after reset", 40'(rd), 40'h0);
    read_reg(2'd0, rd);
    check(rd == 32'h0, "R1 start address after reset", 40'(rd), 40'h0);

    // Program and read back: R1
    write_reg(2'd0, 32'h0000_1000);
    write_reg(2'd1, 32'd5);
    read_reg(2'd0, rd);
    check(rd == 32'h1000, "R1 start address readback", 40'(rd), 40'h1000);
    read_reg(2'd1, rd);
    check(rd == 32'd5, "R1 byte count readback", 40'(rd), 40'd5);
    read_reg(2'd2, rd);
    check(rd == 32'd0, "R1 control reads zero", 40'(rd), 40'd0);

    // Input offered before go: R2
    in_valid = 1'b1; in_data = 8'hEE;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      check(in_ready == 1'b0 && bus_req == 1'b0, "R2 no activity before go", {in_ready, bus_req}, 40'h0);
    end
    in_valid = 1'b0;

    // Go: R3, R13
    gnt_mode = 2'd2;
    exp_addr = 32'h1000;
    write_reg(2'd2, 32'h1);
    read_reg(2'd3, rd);
    check(rd == 32'h15, "R3 status after go", 40'(rd), 40'h15);

    // Stream with alternating grants: R4, R8, R9
    for (int i = 0; i < 5; i++) send_byte(8'hA0 + 8'(i));
    drain();
    #1;
    check(irq == 1'b1, "R8 irq after last byte", 40'(irq), 40'h1);
    read_reg(2'd3, rd);
    check(rd == 32'h2, "R13 status done", 40'(rd), 40'h2);
    #1;
    check(irq == 1'b0, "R9 status read acknowledges", 40'(irq), 40'h0);

    // Zero length: R11, then control acknowledge: R9
    write_reg(2'd1, 32'd0);
    write_reg(2'd2, 32'h1);
    #1;
    check(irq == 1'b1 && bus_req == 1'b0, "R11 zero length completes", {irq, bus_req}, 40'h2);
    read_reg(2'd1, rd);
    check(irq == 1'b1, "R9 non-status read keeps irq", 40'(irq), 40'h1);
    write_reg(2'd2, 32'h2);
    #1;
    check(irq == 1'b0, "R9 control acknowledge", 40'(irq), 40'h0);

    // Go while busy ignored: R10
    gnt_mode = 2'd1;
    write_reg(2'd0, 32'h2000);
    write_reg(2'd1, 32'd3);
    write_reg(2'd2, 32'h1);
    exp_addr = 32'h2000;
    send_byte(8'h11);
    drain();
    write_reg(2'd0, 32'h3000);
    write_reg(2'd1, 32'd7);
    write_reg(2'd2, 32'h1);
    read_reg(2'd3, rd);
    check(rd == 32'h9, "R10 go while busy ignored", 40'(rd), 40'h9);
    send_byte(8'h22);
    send_byte(8'h33);
    drain();
    #1;
    check(irq == 1'b1, "R8 irq after restart attempt", 40'(irq), 40'h1);
    write_reg(2'd2, 32'h2);

    // Withheld grant, step, then collision: R5, R6, R7, R12
    gnt_mode = 2'd0;
    write_reg(2'd0, 32'h4000);
    write_reg(2'd1, 32'd2);
    write_reg(2'd2, 32'h1);
    exp_addr = 32'h4000;
    send_byte(8'h5A);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      check(bus_req == 1'b1 && mem_addr == 32'h4000 && mem_wdata == 8'h5A,
            "R5 held until grant", {mem_addr, mem_wdata}, {32'h4000, 8'h5A});
      check(in_ready == 1'b0, "R6 ready low while waiting", 40'(in_ready), 40'h0);
    end
    @(negedge clk); force_gnt = 1'b1;
    @(negedge clk); force_gnt = 1'b0;
    #1;
    check(mem_addr == 32'h4001, "R7 address stepped", 40'(mem_addr), 40'h4001);
    read_reg(2'd3, rd);
    check(rd == 32'h5, "R7 remaining stepped", 40'(rd), 40'h5);
    send_byte(8'h66);
    @(negedge clk);
    force_gnt = 1'b1; cfg_re = 1'b1; cfg_addr = 2'd3;
    #1 rd = cfg_rdata;
    check(rd == 32'h5, "R12 status in collision cycle", 40'(rd), 40'h5);
    @(negedge clk);
    force_gnt = 1'b0; cfg_re = 1'b0;
    #1;
    check(irq == 1'b1, "R12 completion wins over acknowledge", 40'(irq), 40'h1);
    read_reg(2'd3, rd);
    check(rd == 32'h2, "R12 done reported", 40'(rd), 40'h2);
    #1;
    check(irq == 1'b0 && exp_q.size() == 0, "R9 final acknowledge", {irq, 32'(exp_q.size())}, 40'h0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule